// File: doc/BRIEF.md
# Transmit Ring Halt Controller

This block keeps the halt state of the transmit buffer-descriptor rings in a DMA-driven Ethernet transmitter. Each ring has one sticky halt flag. A flag is set when hardware finds a fault, and software clears it by writing a one to that flag's position. Every fetch result from the descriptor engine is sorted into one of three cases. A bus fault (bad address or uncorrectable read) or a descriptor marked ready with zero length is a general transmit error. Such an error halts every ring and raises a sticky error event. A fetch that finds no ready descriptor halts only the ring it came from.

The block drives a per-ring DMA enable toward the ring scheduler. That enable is removed from halted rings, from rings software has not enabled, and from all rings while a graceful stop is requested. A round-robin picker inside the block names the next ring to fetch from. It moves on each time a descriptor fetch completes. A small register port gives software access to the halt flags, the error event and its interrupt mask.

Top module: `txring_halt_ctrl`

## Requirements
- R1: `dma_en[n]` is 1 exactly when `ring_enable[n]` is 1, ring n's halt flag is 0 and `gstop_req` is 0.
- R2: Writing the halt register (address 0) clears each halt flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R3: An invalid-address indication (`bus_err_addr`) sets every halt flag and the error event on the next edge, whatever `ring_enable` holds.
- R4: An uncorrectable read indication (`bus_err_ecc`) sets every halt flag and the error event on the next edge, whatever `ring_enable` holds.
- R5: A completed fetch with `fetch_ready`=1 and `fetch_len`=0 sets every halt flag and the error event on the next edge.
- R6: A completed fetch with `fetch_ready`=0 sets only the halt flag of `fetch_ring` and leaves the error event unchanged.
- R7: `gstop_req` never sets a halt flag. While it is high, `sched_valid` and every `dma_en` bit are 0.
- R8: The halt register reads with bit n equal to ring n's flag (bits 0..7), and bits 31..8 always read 0.
- R9: When a hardware set and a software write-one clear hit the same flag (halt or error event) in one cycle, the flag ends at 1.
- R10: The error event reads at bit 0 of address 1 and is cleared by writing 1 there. The mask reads and writes at bit 0 of address 2. `irq` equals event AND mask.
- R11: `sched_ring` is the first ring with `dma_en` set, searching upward with wraparound from the one after the ring last granted. The grant moves only on a cycle with `fetch_done`=1 and `sched_valid`=1.
- R12: After reset, all halt flags, the error event and the mask are 0, and the first grant searches from ring 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_done | input | 1 | A descriptor fetch completed this cycle |
| fetch_ring | input | 3 | Ring the fetch belonged to |
| fetch_ready | input | 1 | Fetched descriptor was marked ready |
| fetch_len | input | 16 | Length field of the fetched descriptor |
| bus_err_addr | input | 1 | Invalid descriptor or data address |
| bus_err_ecc | input | 1 | Uncorrectable error on descriptor or data read |
| ring_enable | input | 8 | Software ring enables |
| gstop_req | input | 1 | Graceful transmit stop request |
| csr_wr_en | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address: 0 halt, 1 event, 2 mask |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| dma_en | output | 8 | Per-ring DMA permission |
| sched_ring | output | 3 | Ring granted for the next fetch |
| sched_valid | output | 1 | Some ring is eligible |
| irq | output | 1 | Error event interrupt |

## Verification
Several situations take deliberate setup. One is a hardware set and a software clear landing on the same flag in the same cycle. Another is the round-robin order around halted holes in the enable pattern. The bench produces the collision by pulsing a bus error in the same cycle as an all-ones clear write, on both the halt and the event registers. It checks the round-robin order by taking the current grant as the origin. It then predicts each following grant arithmetically from the enable and halt patterns, one fetch at a time, including a ring that was halted by an empty fetch in the middle of the sequence.

// File: rtl/txh_pkg.sv
package txh_pkg;

    localparam int NUM_RINGS_DEF = 8;
    localparam int LEN_W_DEF     = 16;
    localparam int REG_W         = 32;

    typedef enum logic [1:0] {
        CSR_HALT  = 2'd0,
        CSR_EVENT = 2'd1,
        CSR_MASK  = 2'd2
    } csr_addr_e;

    typedef enum logic [1:0] {
        FK_NONE     = 2'd0,
        FK_GOOD     = 2'd1,
        FK_EMPTY    = 2'd2,
        FK_ZERO_LEN = 2'd3
    } fetch_kind_e;

    typedef struct packed {
        logic addr_fault;
        logic ecc_fault;
        logic prog_fault;
    } err_src_t;

    function automatic logic any_err(input err_src_t e);
        return e.addr_fault | e.ecc_fault | e.prog_fault;
    endfunction

endpackage

// File: rtl/txh_classify.sv
module txh_classify
    import txh_pkg::*;
#(
    parameter int NUM_RINGS = NUM_RINGS_DEF,
    parameter int LEN_W     = LEN_W_DEF,
    localparam int RIDX_W   = $clog2(NUM_RINGS)
) (
    input  logic                 fetch_done,
    input  logic [RIDX_W-1:0]    fetch_ring,
    input  logic                 fetch_ready,
    input  logic [LEN_W-1:0]     fetch_len,
    input  logic                 bus_err_addr,
    input  logic                 bus_err_ecc,
    output logic                 gen_err,
    output logic [NUM_RINGS-1:0] empty_set
);

    fetch_kind_e kind;
    err_src_t    src;

    always_comb begin
        if (!fetch_done)                 kind = FK_NONE;
        else if (!fetch_ready)           kind = FK_EMPTY;
        else if (fetch_len == '0)        kind = FK_ZERO_LEN;
        else                             kind = FK_GOOD;
    end

    always_comb begin
        src.addr_fault = bus_err_addr;
        src.ecc_fault  = bus_err_ecc;
        src.prog_fault = (kind == FK_ZERO_LEN);
        gen_err        = any_err(src);
    end

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_empty
        assign empty_set[g] = (kind == FK_EMPTY) && (int'(fetch_ring) == g);
    end

endmodule

// File: rtl/txh_halt_regs.sv
module txh_halt_regs
    import txh_pkg::*;
#(
    parameter int NUM_RINGS = NUM_RINGS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gen_err,
    input  logic [NUM_RINGS-1:0] empty_set,
    input  logic                 csr_wr_en,
    input  logic [1:0]           csr_addr,
    input  logic [REG_W-1:0]     csr_wdata,
    output logic [NUM_RINGS-1:0] halt_q,
    output logic                 txe_q,
    output logic                 mask_q
);

    logic [NUM_RINGS-1:0] halt_clr;
    logic [NUM_RINGS-1:0] halt_set;
    logic                 txe_clr;
    logic                 mask_wr;

    always_comb begin
        halt_clr = '0;
        txe_clr  = 1'b0;
        mask_wr  = 1'b0;
        if (csr_wr_en) begin
            case (csr_addr_e'(csr_addr))
                CSR_HALT:  halt_clr = csr_wdata[NUM_RINGS-1:0];
                CSR_EVENT: txe_clr  = csr_wdata[0];
                CSR_MASK:  mask_wr  = 1'b1;
                default:   ;
            endcase
        end
        halt_set = {NUM_RINGS{gen_err}} | empty_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= '0;
            txe_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            halt_q <= (halt_q & ~halt_clr) | halt_set;
            txe_q  <= (txe_q & ~txe_clr) | gen_err;
            if (mask_wr) mask_q <= csr_wdata[0];
        end
    end

endmodule

// File: rtl/txh_rr_sched.sv
module txh_rr_sched
    import txh_pkg::*;
#(
    parameter int NUM_RINGS = NUM_RINGS_DEF,
    localparam int RIDX_W   = $clog2(NUM_RINGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RINGS-1:0] eligible,
    input  logic                 advance,
    output logic [RIDX_W-1:0]    grant,
    output logic                 grant_valid
);

    logic [RIDX_W-1:0] last_q;

    always_comb begin
        grant       = '0;
        grant_valid = 1'b0;
        for (int i = NUM_RINGS; i >= 1; i--) begin
            int idx;
            idx = (int'(last_q) + i) % NUM_RINGS;
            if (eligible[idx]) begin
                grant       = RIDX_W'(idx);
                grant_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                           last_q <= RIDX_W'(NUM_RINGS - 1);
        else if (advance && grant_valid)   last_q <= grant;
    end

endmodule

// File: rtl/txring_halt_ctrl.sv
module txring_halt_ctrl
    import txh_pkg::*;
#(
    parameter int NUM_RINGS = NUM_RINGS_DEF,
    parameter int LEN_W     = LEN_W_DEF,
    localparam int RIDX_W   = $clog2(NUM_RINGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch_done,
    input  logic [RIDX_W-1:0]    fetch_ring,
    input  logic                 fetch_ready,
    input  logic [LEN_W-1:0]     fetch_len,
    input  logic                 bus_err_addr,
    input  logic                 bus_err_ecc,
    input  logic [NUM_RINGS-1:0] ring_enable,
    input  logic                 gstop_req,
    input  logic                 csr_wr_en,
    input  logic [1:0]           csr_addr,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    output logic [NUM_RINGS-1:0] dma_en,
    output logic [RIDX_W-1:0]    sched_ring,
    output logic                 sched_valid,
    output logic                 irq
);

    logic                 gen_err;
    logic [NUM_RINGS-1:0] empty_set;
    logic [NUM_RINGS-1:0] halt_q;
    logic                 txe_q;
    logic                 mask_q;
    logic [NUM_RINGS-1:0] eligible;

    txh_classify #(.NUM_RINGS(NUM_RINGS), .LEN_W(LEN_W)) u_classify (
        .fetch_done   (fetch_done),
        .fetch_ring   (fetch_ring),
        .fetch_ready  (fetch_ready),
        .fetch_len    (fetch_len),
        .bus_err_addr (bus_err_addr),
        .bus_err_ecc  (bus_err_ecc),
        .gen_err      (gen_err),
        .empty_set    (empty_set)
    );

    txh_halt_regs #(.NUM_RINGS(NUM_RINGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .gen_err   (gen_err),
        .empty_set (empty_set),
        .csr_wr_en (csr_wr_en),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .halt_q    (halt_q),
        .txe_q     (txe_q),
        .mask_q    (mask_q)
    );

    assign eligible = ring_enable & ~halt_q & {NUM_RINGS{~gstop_req}};
    assign dma_en   = eligible;

    txh_rr_sched #(.NUM_RINGS(NUM_RINGS)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .eligible    (eligible),
        .advance     (fetch_done),
        .grant       (sched_ring),
        .grant_valid (sched_valid)
    );

    always_comb begin
        csr_rdata = '0;
        case (csr_addr_e'(csr_addr))
            CSR_HALT:  csr_rdata[NUM_RINGS-1:0] = halt_q;
            CSR_EVENT: csr_rdata[0] = txe_q;
            CSR_MASK:  csr_rdata[0] = mask_q;
            default:   ;
        endcase
    end

    assign irq = txe_q & mask_q;

endmodule

// File: rtl/txh_checker.sv
module txh_checker #(
    parameter int NUM_RINGS = 8,
    parameter int LEN_W     = 16,
    localparam int RIDX_W   = $clog2(NUM_RINGS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fetch_done,
    input logic [RIDX_W-1:0]    fetch_ring,
    input logic                 fetch_ready,
    input logic [LEN_W-1:0]     fetch_len,
    input logic                 bus_err_addr,
    input logic                 bus_err_ecc,
    input logic                 gstop_req,
    input logic                 csr_wr_en,
    input logic [1:0]           csr_addr,
    input logic [31:0]          csr_wdata,
    input logic [NUM_RINGS-1:0] dma_en,
    input logic [NUM_RINGS-1:0] halt_q,
    input logic                 txe_q,
    input logic                 irq,
    input logic [RIDX_W-1:0]    sched_ring,
    input logic                 sched_valid
);

    logic                 any_fault;
    logic                 empty_fetch;
    logic [NUM_RINGS-1:0] wr_clear;

    assign any_fault   = bus_err_addr | bus_err_ecc |
                         (fetch_done & fetch_ready & (fetch_len == '0));
    assign empty_fetch = fetch_done & ~fetch_ready;
    assign wr_clear    = (csr_wr_en && csr_addr == 2'd0) ? csr_wdata[NUM_RINGS-1:0] : '0;

    assert_halted_no_dma_R1: assert property (@(posedge clk) disable iff (rst)
        (halt_q & dma_en) == '0);

    assert_clear_needs_one_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(halt_q) & ~halt_q & ~$past(wr_clear)) == '0));

    assert_fault_halts_all_R3: assert property (@(posedge clk) disable iff (rst)
        any_fault |=> (&halt_q) && txe_q);

    assert_empty_halts_ring_R6: assert property (@(posedge clk) disable iff (rst)
        empty_fetch |=> halt_q[$past(fetch_ring)]);

    assert_empty_no_event_R6: assert property (@(posedge clk) disable iff (rst)
        (empty_fetch && !any_fault && !txe_q) |=> !txe_q);

    assert_gstop_no_set_R7: assert property (@(posedge clk) disable iff (rst)
        (gstop_req && !any_fault && !empty_fetch) |=> ((halt_q & ~$past(halt_q)) == '0));

    assert_gstop_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        gstop_req |-> (dma_en == '0) && !sched_valid);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (any_fault && csr_wr_en && csr_addr == 2'd0) |=> (&halt_q));

    assert_irq_needs_event_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> txe_q);

    assert_grant_eligible_R11: assert property (@(posedge clk) disable iff (rst)
        sched_valid |-> dma_en[sched_ring]);

    assert_valid_matches_R11: assert property (@(posedge clk) disable iff (rst)
        sched_valid == (dma_en != '0));

endmodule

bind txring_halt_ctrl txh_checker #(.NUM_RINGS(NUM_RINGS), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_done   (fetch_done),
    .fetch_ring   (fetch_ring),
    .fetch_ready  (fetch_ready),
    .fetch_len    (fetch_len),
    .bus_err_addr (bus_err_addr),
    .bus_err_ecc  (bus_err_ecc),
    .gstop_req    (gstop_req),
    .csr_wr_en    (csr_wr_en),
    .csr_addr     (csr_addr),
    .csr_wdata    (csr_wdata),
    .dma_en       (dma_en),
    .halt_q       (halt_q),
    .txe_q        (txe_q),
    .irq          (irq),
    .sched_ring   (sched_ring),
    .sched_valid  (sched_valid)
);

// File: tb/txring_halt_ctrl_tb.sv
module txring_halt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_done = 1'b0;
    logic [2:0]  fetch_ring = '0;
    logic        fetch_ready = 1'b0;
    logic [15:0] fetch_len = '0;
    logic        bus_err_addr = 1'b0;
    logic        bus_err_ecc = 1'b0;
    logic [7:0]  ring_enable = '0;
    logic        gstop_req = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [7:0]  dma_en;
    logic [2:0]  sched_ring;
    logic        sched_valid;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    txring_halt_ctrl u_dut (
        .clk(clk), .rst(rst), .fetch_done(fetch_done), .fetch_ring(fetch_ring),
        .fetch_ready(fetch_ready), .fetch_len(fetch_len), .bus_err_addr(bus_err_addr),
        .bus_err_ecc(bus_err_ecc), .ring_enable(ring_enable), .gstop_req(gstop_req),
        .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .dma_en(dma_en), .sched_ring(sched_ring),
        .sched_valid(sched_valid), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr_en = 1'b0; csr_wdata = '0;
    endtask

    task automatic clr_all();
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h1);
    endtask

    task automatic fetch(input logic [2:0] r, input logic rdy, input logic [15:0] len);
        fetch_done = 1'b1; fetch_ring = r; fetch_ready = rdy; fetch_len = len;
        @(negedge clk);
        fetch_done = 1'b0; fetch_ready = 1'b0; fetch_len = '0;
    endtask

    task automatic fault(input int kind);
        if (kind == 0) bus_err_addr = 1'b1;
        else if (kind == 1) bus_err_ecc = 1'b1;
        else begin fetch_done = 1'b1; fetch_ready = 1'b1; fetch_len = '0; fetch_ring = 3'd2; end
        @(negedge clk);
        bus_err_addr = 1'b0; bus_err_ecc = 1'b0; fetch_done = 1'b0; fetch_ready = 1'b0;
    endtask

    function automatic int next_elig(input int from, input logic [7:0] el);
        for (int i = 1; i <= 8; i++) begin
            if (el[(from + i) % 8]) return (from + i) % 8;
        end
        return -1;
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  pats [4];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        rd(2'd0, v); chk("R12 halt", v, 0);
        rd(2'd1, v); chk("R12 event", v, 0);
        rd(2'd2, v); chk("R12 mask", v, 0);
        chk("R12 irq", {31'd0, irq}, 0);
        ring_enable = 8'hFF; #1;
        chk("R12 first grant", {29'd0, sched_ring}, 0);
        chk("R1 dma after reset", {24'd0, dma_en}, 32'hFF);

        // R6 empty fetch per ring
        for (int r = 0; r < 8; r++) begin
            clr_all();
            fetch(3'(r), 1'b0, 16'd100);
            rd(2'd0, v); chk("R6 only ring halted", v, 32'd1 << r);
            rd(2'd1, v); chk("R6 no event", v, 0);
            chk("R1 dma minus halted", {24'd0, dma_en}, 32'hFF & ~(32'd1 << r));
        end

        // R3/R4/R5 general errors over enable patterns
        pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hFF; pats[3] = 8'h01;
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 3; k++) begin
                ring_enable = pats[p];
                clr_all();
                fault(k);
                rd(2'd0, v);
                chk(k == 0 ? "R3 all halted" : k == 1 ? "R4 all halted" : "R5 all halted", v, 32'hFF);
                rd(2'd1, v);
                chk(k == 0 ? "R3 event" : k == 1 ? "R4 event" : "R5 event", v, 1);
                chk("R1 dma off", {24'd0, dma_en}, 0);
            end
        end

        // R8 upper bits of halt register stay zero
        ring_enable = 8'hFF;
        wr(2'd0, 32'hFFFF_FF00);
        rd(2'd0, v); chk("R8 upper zero", v, 32'hFF);

        // R2 write-one-to-clear sweep
        for (int m = 0; m < 256; m += 17) begin
            fault(0);
            wr(2'd0, 32'(m));
            rd(2'd0, v); chk("R2 w1c", v, 32'(~m & 8'hFF));
        end
        fault(0);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2 zero write", v, 32'hFF);

        // R9 set wins over clear
        clr_all();
        bus_err_ecc = 1'b1; csr_wr_en = 1'b1; csr_addr = 2'd0; csr_wdata = 32'hFF;
        @(negedge clk);
        csr_wr_en = 1'b0; csr_addr = 2'd1; csr_wdata = 32'h1; csr_wr_en = 1'b1;
        @(negedge clk);
        bus_err_ecc = 1'b0; csr_wr_en = 1'b0;
        rd(2'd0, v); chk("R9 halt set wins", v, 32'hFF);
        rd(2'd1, v); chk("R9 event set wins", v, 1);

        // R7 graceful stop
        clr_all();
        gstop_req = 1'b1;
        #1;
        chk("R7 dma off", {24'd0, dma_en}, 0);
        chk("R7 no grant", {31'd0, sched_valid}, 0);
        fetch(3'd3, 1'b1, 16'd64);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R7 no halt", v, 0);
        gstop_req = 1'b0;
        #1;
        chk("R7 release", {24'd0, dma_en}, 32'hFF);

        // R10 interrupt truth table
        for (int e = 0; e < 2; e++) begin
            for (int mk = 0; mk < 2; mk++) begin
                clr_all();
                wr(2'd2, 32'(mk));
                if (e == 1) fault(0);
                rd(2'd2, v); chk("R10 mask readback", v, 32'(mk));
                chk("R10 irq", {31'd0, irq}, 32'(e & mk));
            end
        end
        wr(2'd1, 32'h1);
        chk("R10 irq cleared", {31'd0, irq}, 0);
        wr(2'd2, 32'h0);

        // R11 round robin
        clr_all();
        pats[0] = 8'hFF; pats[1] = 8'h81; pats[2] = 8'h24; pats[3] = 8'hD6;
        for (int p = 0; p < 4; p++) begin
            int cur;
            ring_enable = pats[p];
            #1;
            cur = int'(sched_ring);
            chk("R11 grant enabled", {31'd0, ring_enable[cur]}, 1);
            for (int s = 0; s < 10; s++) begin
                int exp_n;
                exp_n = next_elig(cur, ring_enable);
                fetch(3'(cur), 1'b1, 16'd64);
                chk("R11 next grant", {29'd0, sched_ring}, 32'(exp_n));
                cur = exp_n;
            end
        end
        // R11 with a ring halted mid-sequence
        ring_enable = 8'hFF;
        fetch(3'd4, 1'b0, 16'd64);
        #1;
        begin
            int cur;
            cur = int'(sched_ring);
            for (int s = 0; s < 9; s++) begin
                int exp_n;
                exp_n = next_elig(cur, 8'hEF);
                fetch(3'(cur), 1'b1, 16'd64);
                chk("R11 skips halted", {29'd0, sched_ring}, 32'(exp_n));
                cur = exp_n;
            end
        end
        // R11 no advance without fetch_done
        begin
            logic [2:0] g;
            g = sched_ring;
            repeat (3) @(negedge clk);
            chk("R11 hold", {29'd0, sched_ring}, {29'd0, g});
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule